// File: doc/BRIEF.md
# Directory-Pointer Register Loader

This block keeps the four 64-bit top-level pointer entries of a three-level, 36-bit-style translation scheme in on-chip registers. The table they come from is 32 bytes long. Each entry covers one quarter (1 GB) of the 32-bit linear space. The block refills all four entries from memory when control-register activity requires it. Once loaded, the entries answer lookups with no further memory traffic: the top two bits of a linear address pick the entry that is returned.

A reload fetches the four entries one after another through a simple request/response port. A new qualifying event during a reload abandons the running sequence and restarts it at the newest table base. The surrounding core supplies three things: the current translation mode and table-base register value, strobes for writes to those registers, and a task-switch strobe that carries the incoming base value.

Top module: `dirptr_loader`

## Requirements
- R1: During and directly after reset, all four entries read zero, `busy` and `mem_req` are low, and the lookup output is zero.
- R2: Mode encoding is 00 = translation off, 01 = 32-bit scheme, 10 = this three-level scheme, 11 = another scheme. A `mode_wr` with `cur_mode` of 00 or 01 and `mode_next` of 10 starts a reload. The reload uses the table base held in `cur_base`.
- R3: A `base_wr` while `cur_mode` is 10 starts a reload from `base_new`, not from `cur_base`. In every table address, bits 4:0 of the base and bits 63:32 of the base are treated as zero and ignored.
- R4: A `ts_wr` while `cur_mode` is 10 starts a reload from `ts_base` only if `ts_base` differs from `cur_base`. An equal value starts nothing.
- R5: The following events start no reload, raise no request and leave all four entries unchanged:
  - a `base_wr` while `cur_mode` is not 10;
  - a `mode_wr` whose old mode is 10 or 11;
  - a `mode_wr` whose new mode is not 10.
- R6: A reload issues exactly four reads, to table base +0, +8, +16 and +24, in that order. Each read is held on `mem_req`/`mem_addr` until the cycle in which `mem_rvalid` is high. A response counts only while `mem_req` is high.
- R7: The response to the read at base + 8·k is written into entry k. `busy` rises in the cycle after the triggering edge. It falls in the cycle after the fourth response is accepted.
- R8: `lookup_entry` always equals the entry whose index is `lin_addr[31:30]` (00 gives entry 0, 11 gives entry 3).
- R9: A trigger during a reload restarts the sequence at entry 0 with the newest base. A response arriving in the trigger cycle is discarded. When several triggers fall in one cycle, `base_wr` takes priority over `ts_wr`, which takes priority over `mode_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mode | input | 2 | Current translation mode |
| cur_base | input | 64 | Current table-base register value |
| mode_wr | input | 1 | Mode register write strobe |
| mode_next | input | 2 | Mode being written |
| base_wr | input | 1 | Table-base register write strobe |
| base_new | input | 64 | Base value being written |
| ts_wr | input | 1 | Task-switch strobe |
| ts_base | input | 64 | Base value carried by the task switch |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Byte address of the requested entry |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data |
| lin_addr | input | 32 | Linear address for lookup |
| lookup_entry | output | 64 | Entry selected by `lin_addr[31:30]` |
| ptr_regs | output | 4x64 | All four entries |
| busy | output | 1 | Reload in progress |

## Verification
The assertions check the cycle-level behaviour on every clock:
- the ordering and alignment of the read addresses;
- the step from one entry to the next on each accepted response;
- the write of each response into the matching entry;
- the drop of the request after the fourth response;
- the restart at entry 0 on any trigger;
- that the entries cannot change while no reload runs.

Only the bench scenarios can show the end-to-end results. These are the data loaded from each of the three trigger sources, that the ignored base bits have no effect, the non-triggering cases, the outcome of a restart in the middle of a reload, and lookups over all four quarters.

// File: rtl/dirptr_loader.sv
module dirptr_loader #(
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int NENT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cur_mode,
  input  logic [DW-1:0]            cur_base,
  input  logic                     mode_wr,
  input  logic [1:0]               mode_next,
  input  logic                     base_wr,
  input  logic [DW-1:0]            base_new,
  input  logic                     ts_wr,
  input  logic [DW-1:0]            ts_base,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata,
  input  logic [AW-1:0]            lin_addr,
  output logic [DW-1:0]            lookup_entry,
  output logic [NENT-1:0][DW-1:0]  ptr_regs,
  output logic                     busy
);
  localparam int IW = $clog2(NENT);
  localparam int OB = $clog2(DW/8);
  localparam int LB = IW + OB;
  localparam logic [1:0] M_PAE = 2'b10;

  logic [AW-1:LB] tbl;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  tgt;

  wire in_pae = (cur_mode == M_PAE);
  wire t_base = base_wr && in_pae;
  wire t_ts   = ts_wr && in_pae && (ts_base != cur_base);
  wire t_mode = mode_wr && !cur_mode[1] && (mode_next == M_PAE);
  wire trig   = t_base || t_ts || t_mode;
  wire take   = busy && mem_rvalid && !trig;

  assign tgt = t_base ? base_new : (t_ts ? ts_base : cur_base);
  assign mem_req = busy;
  assign mem_addr = {tbl, idx, OB'(0)};
  assign lookup_entry = ptr_regs[lin_addr[AW-1 -: IW]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      tbl  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      idx  <= '0;
      tbl  <= tgt[AW-1:LB];
    end else if (take) begin
      idx <= idx + 1'b1;
      if (idx == IW'(NENT-1)) busy <= 1'b0;
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ptr_regs[g] <= '0;
      else if (take && idx == IW'(g)) ptr_regs[g] <= mem_rdata;
    end
  end
endmodule

module dirptr_loader_chk #(
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int NENT = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              cur_mode,
  input logic [DW-1:0]           cur_base,
  input logic                    mode_wr,
  input logic [1:0]              mode_next,
  input logic                    base_wr,
  input logic [DW-1:0]           base_new,
  input logic                    ts_wr,
  input logic [DW-1:0]           ts_base,
  input logic                    mem_req,
  input logic [AW-1:0]           mem_addr,
  input logic                    mem_rvalid,
  input logic [DW-1:0]           mem_rdata,
  input logic [AW-1:0]           lin_addr,
  input logic [DW-1:0]           lookup_entry,
  input logic [NENT-1:0][DW-1:0] ptr_regs,
  input logic                    busy
);
  localparam int IW = $clog2(NENT);
  localparam int OB = $clog2(DW/8);
  localparam int LB = IW + OB;

  wire pae_now = (cur_mode == 2'b10);
  wire any_trig = (base_wr && pae_now) || (ts_wr && pae_now && ts_base != cur_base)
                  || (mode_wr && (cur_mode == 2'b00 || cur_mode == 2'b01) && mode_next == 2'b10);
  wire last_ent = (mem_addr[LB-1:OB] == IW'(NENT-1));
  wire accepted = mem_req && mem_rvalid && !any_trig;

  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[OB-1:0] == '0);

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && !last_ent |=> mem_req && mem_addr[LB-1:OB] == IW'($past(mem_addr[LB-1:OB]) + 1'b1)
                              && mem_addr[AW-1:LB] == $past(mem_addr[AW-1:LB]));

  a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && last_ent |=> !busy && !mem_req);

  a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> ptr_regs[$past(mem_addr[LB-1:OB])] == $past(mem_rdata));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    any_trig |=> busy && mem_addr[LB-1:OB] == '0);

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !any_trig |=> !busy && $stable(ptr_regs));

  a_r8_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_entry == ptr_regs[lin_addr[AW-1 -: IW]]);

  a_r6_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req == busy);
endmodule

bind dirptr_loader dirptr_loader_chk #(.DW(DW), .AW(AW), .NENT(NENT)) u_chk (.*);

// File: tb/sim_dirptr_loader.sv
module sim_dirptr_loader;
  logic clk = 0, rst_n = 0;
  logic [1:0] cur_mode = 0, mode_next = 0;
  logic [63:0] cur_base = 0, base_new = 0, ts_base = 0;
  logic mode_wr = 0, base_wr = 0, ts_wr = 0;
  logic mem_req, mem_rvalid = 0, busy;
  logic [31:0] mem_addr, lin_addr = 0;
  logic [63:0] mem_rdata = 0, lookup_entry;
  logic [3:0][63:0] ptr_regs;

  int n_chk = 0, n_fail = 0, lat = 0, log_n = 0;
  logic [31:0] log_a [0:63];
  logic [3:0][63:0] snap;

  always #10 clk = ~clk;

  dirptr_loader u0 (.clk, .rst_n, .cur_mode, .cur_base, .mode_wr, .mode_next,
    .base_wr, .base_new, .ts_wr, .ts_base, .mem_req, .mem_addr, .mem_rvalid,
    .mem_rdata, .lin_addr, .lookup_entry, .ptr_regs, .busy);

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, a * 32'h0001_0003 + 32'h77};
  endfunction

  function automatic logic [31:0] tbl_of(input logic [63:0] b);
    return {b[31:5], 5'b0};
  endfunction

  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 0;
    else if (mem_req) begin
      if (lat == 0) begin
        mem_rvalid = 1;
        mem_rdata = mem_word(mem_addr);
        if (log_n < 64) log_a[log_n] = mem_addr;
        log_n++;
        lat = $urandom % 3;
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input int kind, input logic [1:0] m, input logic [63:0] b);
    @(negedge clk);
    log_n = 0;
    case (kind)
      0: begin mode_wr = 1; mode_next = m; end
      1: begin base_wr = 1; base_new = b; end
      default: begin ts_wr = 1; ts_base = b; end
    endcase
    @(negedge clk);
    if (mode_wr) cur_mode = mode_next;
    if (base_wr) cur_base = base_new;
    if (ts_wr) cur_base = ts_base;
    mode_wr = 0; base_wr = 0; ts_wr = 0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
  endtask

  task automatic check_loaded(input logic [63:0] b, input string req);
    logic [31:0] t = tbl_of(b);
    for (int k = 0; k < 4; k++)
      chk(ptr_regs[k] == mem_word(t + 32'(8*k)), req, ptr_regs[k], mem_word(t + 32'(8*k)));
    chk(log_n >= 4, "R6 count", 64'(log_n), 64'd4);
    if (log_n >= 4 && log_n <= 64)
      for (int k = 0; k < 4; k++)
        chk(log_a[log_n-4+k] == t + 32'(8*k), "R6 order", 64'(log_a[log_n-4+k]), 64'(t + 32'(8*k)));
  endtask

  task automatic check_lookup();
    for (int k = 0; k < 4; k++) begin
      lin_addr = {k[1:0], 30'($urandom)};
      #1;
      chk(lookup_entry == ptr_regs[k], "R8 lookup", lookup_entry, ptr_regs[k]);
    end
  endtask

  task automatic check_quiet(input string req);
    chk(!busy && !mem_req, req, 64'(busy), 64'd0);
    chk(ptr_regs == snap, req, ptr_regs[0], snap[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] b, b2;
    void'($urandom(32'd1234));
    cur_base = 64'hFFFF_0000_1234_5678;
    repeat (3) @(negedge clk);
    chk(ptr_regs == '0 && !busy && !mem_req && lookup_entry == 0, "R1 reset", ptr_regs[0], 0);
    rst_n = 1;
    @(negedge clk);
    chk(ptr_regs == '0 && !busy && !mem_req, "R1 after reset", {63'd0, busy}, 0);

    ev(0, 2'b10, 0);
    chk(busy, "R7 busy rise", 64'(busy), 1);
    wait_done();
    check_loaded(64'hFFFF_0000_1234_5678, "R2 off->pae");
    check_lookup();

    ev(0, 2'b01, 0);
    snap = ptr_regs;
    repeat (3) @(negedge clk);
    check_quiet("R5 pae->32");
    ev(1, 0, 64'hDEAD_BEEF_0000_A0FF);
    repeat (3) @(negedge clk);
    check_quiet("R5 base write in 32-bit");
    ev(0, 2'b10, 0);
    wait_done();
    check_loaded(64'hDEAD_BEEF_0000_A0FF, "R2 32->pae");

    snap = ptr_regs;
    ev(0, 2'b10, 0);
    repeat (3) @(negedge clk);
    check_quiet("R5 pae->pae");

    ev(1, 0, 64'h1111_2222_8765_432F);
    wait_done();
    check_loaded(64'h1111_2222_8765_432F, "R3 base write");
    chk(tbl_of(64'h1111_2222_8765_432F) == 32'h8765_4320, "R3 ignored bits", 0, 0);

    snap = ptr_regs;
    ev(2, 0, cur_base);
    repeat (3) @(negedge clk);
    check_quiet("R4 same base");
    ev(2, 0, 64'h0000_0000_0040_0060);
    wait_done();
    check_loaded(64'h0000_0000_0040_0060, "R4 task switch");

    ev(1, 0, 64'h0000_0000_00AB_C000);
    repeat (2) @(negedge clk);
    ev(1, 0, 64'h0000_0000_0DEF_0020);
    wait_done();
    check_loaded(64'h0000_0000_0DEF_0020, "R9 restart");
    check_lookup();

    @(negedge clk);
    log_n = 0;
    base_wr = 1; base_new = 64'h0000_0000_0300_0000;
    ts_wr = 1; ts_base = 64'h0000_0000_0400_0000;
    @(negedge clk);
    cur_base = base_new; base_wr = 0; ts_wr = 0;
    wait_done();
    check_loaded(64'h0000_0000_0300_0000, "R9 priority");

    for (int i = 0; i < 40; i++) begin
      int kind = $urandom % 3;
      logic [1:0] m = 2'($urandom);
      bit exp_t;
      b = {$urandom, $urandom};
      if ($urandom % 4 == 0) b = cur_base;
      exp_t = (kind == 0) ? (cur_mode < 2 && m == 2'b10)
            : (kind == 1) ? (cur_mode == 2'b10)
            : (cur_mode == 2'b10 && b != cur_base);
      b2 = (kind == 0) ? cur_base : b;
      snap = ptr_regs;
      ev(kind, m, b);
      if (exp_t) begin
        wait_done();
        check_loaded(b2, "R2 R3 R4 random");
      end else begin
        repeat (2) @(negedge clk);
        check_quiet("R5 random");
        if (cur_mode != 2'b10) ev(0, 2'b00, 0);
      end
    end
    check_lookup();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule